// File: doc/BRIEF.md
# Seven-Level Staircase Inverter Gate Sequencer

This block drives the gates of a single-phase seven-level staircase inverter. The power stage has three level-select switches (A, B, C), which build a unipolar voltage of zero to three units, and a four-switch unfolding bridge. The bridge works as two pairs: one pair passes that voltage to the load with positive polarity and the other pair passes it with negative polarity. A free-running tick counter splits every half-cycle into seven segments of equal length. The segments step the magnitude up from zero to three and back down to zero. At the end of each half-cycle the bridge changes pair.

The bridge changes pair only during the zero segment at the start of a half-cycle. For the first `DEAD_TICKS` cycles of that segment both pairs are held off. A registered copy of the enable input gates every output. When enable drops, all gates turn off, and when it returns the sequence restarts from the first zero segment of a positive half-cycle. A signed level output reports the commanded level so that a test environment can compare it with the gate pattern. The defaults assume a 250 MHz clock and a 10 ms half-cycle.

Top module: `stair_gate_seq`

## Requirements
- R1: While `rst_ni` is low all gate outputs are 0 and `level_o` is 0. The same holds from the first rising edge at which `en_i` is sampled low until enable is sampled high again.
- R2: Every segment lasts exactly `SEG_TICKS` cycles and every half-cycle lasts exactly seven segments. The first segment begins in the cycle after the first rising edge that samples `en_i` high.
- R3: Within each half-cycle the magnitude of `level_o` runs 0, 1, 2, 3, 2, 1, 0, one value per segment.
- R4: `lvl_gate_o` bit 2 drives switch A, bit 1 drives switch B and bit 0 drives switch C. Magnitude 3 gives 3'b101, magnitude 2 gives 3'b011, magnitude 1 gives 3'b110 and magnitude 0 gives 3'b000. The same code is used in both polarities.
- R5: The first half-cycle after a start is positive: `pair_pos_o` is the active pair and `level_o` is non-negative. The polarity alternates every seven segments, and in a negative half-cycle `pair_neg_o` is the active pair and `level_o` equals minus the magnitude.
- R6: In the first `DEAD_TICKS` cycles of every half-cycle both bridge pairs are off. From cycle `DEAD_TICKS` of that half-cycle to its end the active pair is on. `DEAD_TICKS` must be at least 1 and less than `SEG_TICKS`.
- R7: `pair_pos_o` and `pair_neg_o` are never 1 in the same cycle, and a pair never turns on in the cycle right after the other pair was on.
- R8: After a reset or after enable returns, the sequence restarts at segment 0 of a positive half-cycle, with the dead-time window applied at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low, all gates are off and the sequence is held at its start |
| lvl_gate_o | output | 3 | Level-switch gates: bit 2 for switch A, bit 1 for B, bit 0 for C |
| pair_pos_o | output | 1 | Gate of the positive-polarity bridge pair |
| pair_neg_o | output | 1 | Gate of the negative-polarity bridge pair |
| level_o | output | 3 | Commanded level in two's complement, -3 to +3 |

## Verification
The assertions assume that `DEAD_TICKS` is at least 1 and below `SEG_TICKS`. Under that assumption the pair changeover always falls inside a zero segment, and the check that no pair turns on right after the other one holds at every polarity change. They also assume that `en_i` changes only between clock edges. The bench therefore drives enable and reset at falling edges, with short test parameters (six-cycle segments, two-cycle dead time). It withdraws and reasserts enable in the middle of a half-cycle, and it applies reset during a negative half-cycle, so that both restart paths are exercised.

// File: rtl/stair_pkg.sv
package stair_pkg;
  localparam int unsigned NUM_SEG = 7;
  localparam int unsigned SEG_W   = 3;

  typedef logic [1:0]       mag_t;
  typedef logic [2:0]       gate_t;
  typedef logic [SEG_W-1:0] seg_t;

  // symmetric staircase: rise on segments 0..3, fall on 4..6
  function automatic mag_t seg_to_mag(seg_t seg);
    if (seg <= seg_t'(3)) return mag_t'(seg);
    return mag_t'(seg_t'(NUM_SEG - 1) - seg);
  endfunction

  // bit2 = A, bit1 = B, bit0 = C
  function automatic gate_t mag_to_gate(mag_t m);
    case (m)
      2'd3:    return 3'b101;
      2'd2:    return 3'b011;
      2'd1:    return 3'b110;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/stair_seg_timer.sv
module stair_seg_timer
  import stair_pkg::*;
#(
  parameter int unsigned SEG_TICKS = 357143,
  parameter int unsigned TW        = $clog2(SEG_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [TW-1:0] tick_o,
  output seg_t          seg_o,
  output logic          neg_o
);
  localparam logic [TW-1:0] TICK_LAST = TW'(SEG_TICKS - 1);
  localparam seg_t          SEG_LAST  = seg_t'(NUM_SEG - 1);

  logic [TW-1:0] tick_q;
  seg_t          seg_q;
  logic          neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      seg_q  <= '0;
      neg_q  <= 1'b0;
    end else if (!run_i) begin
      tick_q <= '0;
      seg_q  <= '0;
      neg_q  <= 1'b0;
    end else if (tick_q == TICK_LAST) begin
      tick_q <= '0;
      if (seg_q == SEG_LAST) begin
        seg_q <= '0;
        neg_q <= ~neg_q;
      end else begin
        seg_q <= seg_q + seg_t'(1);
      end
    end else begin
      tick_q <= tick_q + TW'(1);
    end
  end

  assign tick_o = tick_q;
  assign seg_o  = seg_q;
  assign neg_o  = neg_q;

  p_seg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_q != TICK_LAST |=> seg_q == $past(seg_q) && tick_q == $past(tick_q) + TW'(1));
  p_seg_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_q == TICK_LAST |=> tick_q == '0 && seg_q != $past(seg_q));
  p_seg_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q <= SEG_LAST);
  p_pol_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !(seg_q == SEG_LAST && tick_q == TICK_LAST) |=> $stable(neg_q));
  p_idle_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> tick_q == '0 && seg_q == '0 && !neg_q);
endmodule

// File: rtl/stair_level_enc.sv
module stair_level_enc
  import stair_pkg::*;
(
  input  logic              run_i,
  input  seg_t              seg_i,
  input  logic              neg_i,
  output gate_t             gate_o,
  output logic signed [2:0] level_o
);
  mag_t       mag;
  logic [2:0] mag_ext;

  always_comb begin
    mag     = run_i ? seg_to_mag(seg_i) : 2'd0;
    mag_ext = {1'b0, mag};
    gate_o  = mag_to_gate(mag);
    level_o = neg_i ? 3'(-mag_ext) : mag_ext;
  end
endmodule

// File: rtl/stair_bridge_ctl.sv
module stair_bridge_ctl
  import stair_pkg::*;
#(
  parameter int unsigned DEAD_TICKS = 250,
  parameter int unsigned TW         = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] tick_i,
  input  seg_t          seg_i,
  input  logic          neg_i,
  output logic          pos_o,
  output logic          neg_o
);
  logic dead;

  generate
    if (DEAD_TICKS == 0) begin : g_no_dead
      assign dead = 1'b0;
    end else begin : g_dead
      assign dead = (seg_i == '0) && (tick_i < TW'(DEAD_TICKS));
    end
  endgenerate

  assign pos_o = run_i && !neg_i && !dead;
  assign neg_o = run_i &&  neg_i && !dead;

  p_pairs_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));
  p_pos_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_o) |-> !$past(neg_o));
  p_neg_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(neg_o) |-> !$past(pos_o));
endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
  import stair_pkg::*;
#(
  parameter int unsigned SEG_TICKS  = 357143,
  parameter int unsigned DEAD_TICKS = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [2:0]        lvl_gate_o,
  output logic              pair_pos_o,
  output logic              pair_neg_o,
  output logic signed [2:0] level_o
);
  localparam int unsigned TW = $clog2(SEG_TICKS + 1);

  logic          run_q;
  logic [TW-1:0] tick;
  seg_t          seg;
  logic          neg_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  stair_seg_timer #(.SEG_TICKS(SEG_TICKS), .TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_o (tick),
    .seg_o  (seg),
    .neg_o  (neg_half)
  );

  stair_level_enc u_enc (
    .run_i   (run_q),
    .seg_i   (seg),
    .neg_i   (neg_half),
    .gate_o  (lvl_gate_o),
    .level_o (level_o)
  );

  stair_bridge_ctl #(.DEAD_TICKS(DEAD_TICKS), .TW(TW)) u_bridge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (tick),
    .seg_i  (seg),
    .neg_i  (neg_half),
    .pos_o  (pair_pos_o),
    .neg_o  (pair_neg_o)
  );

  p_idle_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> lvl_gate_o == 3'b000 && !pair_pos_o && !pair_neg_o && level_o == 3'sd0);
  p_gate_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lvl_gate_o) != 1 && $countones(lvl_gate_o) != 3);
  p_sign_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_pos_o |-> !level_o[2]) and (pair_neg_o |-> (level_o == 3'sd0 || level_o[2])));
endmodule

// File: tb/stair_gate_seq_tb_top.sv
module stair_gate_seq_tb_top;
  localparam int S   = 6;
  localparam int D   = 2;
  localparam int PER = 14 * S;

  // per segment: {magnitude[4:3], gate code[2:0]}
  localparam logic [4:0] SEG_TAB [7] = '{
    5'b00_000, 5'b01_110, 5'b10_011, 5'b11_101, 5'b10_011, 5'b01_110, 5'b00_000
  };

  logic clk = 1'b0;
  logic rst_n, en;
  logic [2:0] gate;
  logic pp, pn;
  logic signed [2:0] lvl;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stair_gate_seq #(.SEG_TICKS(S), .DEAD_TICKS(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .lvl_gate_o(gate), .pair_pos_o(pp), .pair_neg_o(pn), .level_o(lvl)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_off(string tag);
    chk(tag, {gate, pp, pn, lvl}, 8'h00);
  endtask

  // check running cycle c (c=0 is the first cycle of a half-cycle pair)
  task automatic chk_cycle(int c, string pfx);
    int half = (c / (7 * S)) % 2;
    int h    = c % (7 * S);
    int sg   = h / S;
    int tk   = h % S;
    logic [4:0] e = SEG_TAB[sg];
    logic [2:0] lv = {1'b0, e[4:3]};
    logic dead = (sg == 0) && (tk < D);
    logic ep = (half == 0) && !dead;
    logic en_ = (half == 1) && !dead;
    if (half == 1) lv = -lv;
    chk({pfx, " R4 gates"}, {5'b0, gate}, {5'b0, e[2:0]});
    chk({pfx, " R2 R3 level"}, {5'b0, lvl}, {5'b0, lv});
    if (sg == 0 && tk <= D) chk({pfx, " R6 pairs"}, {6'b0, pp, pn}, {6'b0, ep, en_});
    else                    chk({pfx, " R5 pairs"}, {6'b0, pp, pn}, {6'b0, ep, en_});
    chk({pfx, " R7 exclusive"}, {7'b0, pp & pn}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    repeat (3) @(negedge clk);
    chk_off("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_off("R1 enable low");

    // main walk: two full periods
    en = 1'b1;
    for (int c = 0; c < 2 * PER; c++) begin
      @(negedge clk);
      chk_cycle(c, "walk");
    end

    // enable withdrawn mid half-cycle
    repeat (16) @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk_off("R1 enable dropped");
    end
    en = 1'b1;
    for (int c = 0; c < 10 * S; c++) begin
      @(negedge clk);
      chk_cycle(c, "R8 re-enable");
    end

    // async reset inside a negative half-cycle
    #1 rst_n = 1'b0;
    #1 chk_off("R1 async reset");
    @(negedge clk);
    chk_off("R1 held reset");
    rst_n = 1'b1;
    for (int c = 0; c < 2 * S; c++) begin
      @(negedge clk);
      chk_cycle(c, "R8 after reset");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule